// File: doc/BRIEF.md
# DMA Channel Control-Status Register Bank

This block holds the software-visible registers of each channel of a descriptor-driven DMA engine. It sits on a simple 32-bit memory-mapped bus. Each channel owns a 256-byte window, and channel n starts at byte address 0x8000 + n*0x100. Inside a channel window there is a 64-bit command pointer made of two halves and a 16-bit status word. There are also three condition-select registers, one each for the interrupt, branch and wait conditions.

Software never writes the status word directly. It writes a control word instead: the upper half of that word chooses which status bits change, and the lower half gives their new values. The channel engine changes status through its own masked update port. When both touch the same bit in the same cycle, the bus write wins.

Each select register compares the low eight status bits, the device-dependent ones, through its mask against its compare value. The results drive the interrupt, branch and wait condition outputs of the channel. Those outputs are combinational from the registered state.

Top module: `dma_chan_csr`

## Requirements
- R1: Channel n decodes at BASE_ADDR + n*CHAN_SPAN (defaults 0x8000 and 0x100). The word offsets are: 0x00 control, 0x04 status, 0x08 pointer high, 0x0C pointer low, 0x10 interrupt select, 0x14 branch select, 0x18 wait select. Any other offset, or an address outside the channel windows, reads as zero and ignores writes.
- R2: A write to the control offset updates only the status bits whose bit in data[31:16] is 1. Each such bit takes the matching bit of data[15:0]. All other status bits keep their value.
- R3: A read at the status offset or the control offset returns {16'h0, status}. A bus write to the status offset leaves status unchanged.
- R4: A select register stores its mask in bits 23:16 and its compare value in bits 7:0. Bits 31:24 and 15:8 read as zero, whatever was written to them.
- R5: Each condition output is 1 exactly when (select mask AND status[7:0]) == select value. The interrupt, branch and wait outputs each use their own select register.
- R6: Reset clears every register to zero, so all three condition outputs of every channel are 1.
- R7: A pulse on engUpdEn[n] for one cycle sets status = (status AND NOT mask) OR (value AND mask) for channel n. In a cycle that also holds a control write, bits in the control mask take the bus value and the remaining engine-masked bits take the engine value.
- R8: A condition output reflects a status or select change in the first cycle after the clock edge that loads the change.
- R9: The pointer halves read back what was last written to them. cmdPtr[n*64 +: 64] presents {high, low} for channel n.
- R10: A write to one channel changes no register of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| engUpdEn | input | NUM_CHAN | Engine status update strobe, one per channel |
| engUpdMask | input | NUM_CHAN*16 | Engine update bit mask per channel |
| engUpdVal | input | NUM_CHAN*16 | Engine update values per channel |
| condIntr | output | NUM_CHAN | Interrupt condition per channel |
| condBranch | output | NUM_CHAN | Branch condition per channel |
| condWait | output | NUM_CHAN | Wait condition per channel |
| cmdPtr | output | NUM_CHAN*64 | Command pointer {high, low} per channel |

## Verification
A table drives the masked status update and the interrupt compare with a set of control words: full masks, partial masks, a zero mask and a mask covering only the upper byte. Each is paired with a select word whose expected result is either a match or a near-miss. This separates a write that ignores its mask, a compare that ignores the select mask, and a compare that looks at the wrong status byte. Directed cases then cover several things:
- successive partial writes, to show that unmasked bits are kept;
- the ignored direct write to status;
- the reserved select bits;
- an engine update that coincides with a bus write, where overlapping and disjoint bits must resolve differently;
- out-of-window addresses;
- a second reset in mid-run.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int REG_W  = 32;
  localparam int STAT_W = 16;
  localparam int DEV_W  = 8;
  localparam int NUM_SEL = 3;

  // Word offsets within a channel window
  localparam logic [7:0] OFF_CTL     = 8'h00;
  localparam logic [7:0] OFF_STAT    = 8'h04;
  localparam logic [7:0] OFF_PTR_HI  = 8'h08;
  localparam logic [7:0] OFF_PTR_LO  = 8'h0C;
  localparam logic [7:0] OFF_SEL_INT = 8'h10;
  localparam logic [7:0] OFF_SEL_BR  = 8'h14;
  localparam logic [7:0] OFF_SEL_WT  = 8'h18;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STAT,
    RD_PTR_HI,
    RD_PTR_LO,
    RD_SEL_INT,
    RD_SEL_BR,
    RD_SEL_WT
  } rdSel_e;

  typedef struct packed {
    logic wrCtl;
    logic wrPtrHi;
    logic wrPtrLo;
    logic wrSelInt;
    logic wrSelBr;
    logic wrSelWt;
  } csrStrb_t;

endpackage

// File: rtl/dma_cond_eval.sv
module dma_cond_eval #(
  parameter int DEV_BITS = 8
) (
  input  logic [DEV_BITS-1:0] selMask,
  input  logic [DEV_BITS-1:0] selValue,
  input  logic [DEV_BITS-1:0] devBits,
  output logic                condHit
);

  assign condHit = ((selMask & devBits) == selValue);

endmodule

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_csr_pkg::*;
#(
  parameter int NUM_CHAN  = 2,
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 32'h8000,
  parameter int CHAN_SPAN = 256
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      busSel,
  input  logic                      busWrite,
  input  logic [ADDR_W-1:0]         busAddr,
  output csrStrb_t [NUM_CHAN-1:0]   strb,
  output rdSel_e                    rdSel,
  output logic [NUM_CHAN-1:0]       rdHit
);

  localparam int SPAN_LG = $clog2(CHAN_SPAN);
  localparam int CHAN_W  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
  localparam int REL_W   = SPAN_LG + CHAN_W;
  localparam logic [ADDR_W:0]   ADDR_LO   = (ADDR_W+1)'(BASE_ADDR);
  localparam logic [ADDR_W:0]   ADDR_HI   = (ADDR_W+1)'(BASE_ADDR + NUM_CHAN*CHAN_SPAN);
  localparam logic [ADDR_W-1:0] ADDR_BASE = ADDR_W'(BASE_ADDR);

  logic               inRange;
  logic [REL_W-1:0]   relAddr;
  logic [CHAN_W-1:0]  chanIdx;
  logic [SPAN_LG-1:0] regOff;
  csrStrb_t           wrKind;
  rdSel_e             rdKind;
  logic [NUM_CHAN-1:0] anyWr;

  assign inRange = ({1'b0, busAddr} >= ADDR_LO) && ({1'b0, busAddr} < ADDR_HI);
  assign relAddr = REL_W'(busAddr - ADDR_BASE);
  assign chanIdx = relAddr[SPAN_LG +: CHAN_W];
  assign regOff  = relAddr[SPAN_LG-1:0];

  // Offset decode: a write kind and a read source; status offset has no write kind
  always_comb begin
    wrKind = '0;
    rdKind = RD_NONE;
    case (regOff)
      SPAN_LG'(OFF_CTL):     begin wrKind.wrCtl    = 1'b1; rdKind = RD_STAT;    end
      SPAN_LG'(OFF_STAT):    begin                         rdKind = RD_STAT;    end
      SPAN_LG'(OFF_PTR_HI):  begin wrKind.wrPtrHi  = 1'b1; rdKind = RD_PTR_HI;  end
      SPAN_LG'(OFF_PTR_LO):  begin wrKind.wrPtrLo  = 1'b1; rdKind = RD_PTR_LO;  end
      SPAN_LG'(OFF_SEL_INT): begin wrKind.wrSelInt = 1'b1; rdKind = RD_SEL_INT; end
      SPAN_LG'(OFF_SEL_BR):  begin wrKind.wrSelBr  = 1'b1; rdKind = RD_SEL_BR;  end
      SPAN_LG'(OFF_SEL_WT):  begin wrKind.wrSelWt  = 1'b1; rdKind = RD_SEL_WT;  end
      default: ;
    endcase
  end

  assign rdSel = rdKind;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic chanSel;
    assign chanSel  = busSel && inRange && (chanIdx == CHAN_W'(c));
    assign strb[c]  = (chanSel && busWrite) ? wrKind : '0;
    assign rdHit[c] = chanSel && !busWrite;
    assign anyWr[c] = |strb[c];
  end

  AST_ONE_CHAN_WR: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(anyWr)); // R10

  AST_STAT_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && regOff == SPAN_LG'(OFF_STAT)) |-> (anyWr == '0)); // R3

  AST_OUT_RANGE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inRange |-> (anyWr == '0 && rdHit == '0)); // R1

endmodule

// File: rtl/dma_csr_dp.sv
module dma_csr_dp
  import dma_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  csrStrb_t          strb,
  input  logic [REG_W-1:0]  busWdata,
  input  logic              engUpdEn,
  input  logic [STAT_W-1:0] engUpdMask,
  input  logic [STAT_W-1:0] engUpdVal,
  input  rdSel_e            rdSel,
  output logic [REG_W-1:0]  rdData,
  output logic              condIntr,
  output logic              condBranch,
  output logic              condWait,
  output logic [2*REG_W-1:0] cmdPtr
);

  logic [STAT_W-1:0] statusQ, statusNext, engMerged, busMask;
  logic [REG_W-1:0]  ptrHiQ, ptrLoQ;
  logic [NUM_SEL-1:0][DEV_W-1:0] selMaskQ, selValQ;
  logic [NUM_SEL-1:0] selWr, condVec;

  // Engine merge first, then bus control write on top (bus wins overlap)
  assign busMask   = busWdata[REG_W-1:STAT_W];
  assign engMerged = engUpdEn ? ((statusQ & ~engUpdMask) | (engUpdVal & engUpdMask)) : statusQ;
  assign statusNext = strb.wrCtl ? ((engMerged & ~busMask) | (busWdata[STAT_W-1:0] & busMask))
                                 : engMerged;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      ptrHiQ  <= '0;
      ptrLoQ  <= '0;
    end else begin
      statusQ <= statusNext;
      if (strb.wrPtrHi) ptrHiQ <= busWdata;
      if (strb.wrPtrLo) ptrLoQ <= busWdata;
    end
  end

  assign selWr = {strb.wrSelWt, strb.wrSelBr, strb.wrSelInt};

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selMaskQ[i] <= '0;
        selValQ[i]  <= '0;
      end else if (selWr[i]) begin
        selMaskQ[i] <= busWdata[16 +: DEV_W];
        selValQ[i]  <= busWdata[0 +: DEV_W];
      end
    end

    dma_cond_eval #(.DEV_BITS(DEV_W)) u_eval (
      .selMask  (selMaskQ[i]),
      .selValue (selValQ[i]),
      .devBits  (statusQ[DEV_W-1:0]),
      .condHit  (condVec[i])
    );
  end

  assign condIntr   = condVec[0];
  assign condBranch = condVec[1];
  assign condWait   = condVec[2];
  assign cmdPtr     = {ptrHiQ, ptrLoQ};

  always_comb begin
    case (rdSel)
      RD_STAT:    rdData = {{(REG_W-STAT_W){1'b0}}, statusQ};
      RD_PTR_HI:  rdData = ptrHiQ;
      RD_PTR_LO:  rdData = ptrLoQ;
      RD_SEL_INT: rdData = {8'h0, selMaskQ[0], 8'h0, selValQ[0]};
      RD_SEL_BR:  rdData = {8'h0, selMaskQ[1], 8'h0, selValQ[1]};
      RD_SEL_WT:  rdData = {8'h0, selMaskQ[2], 8'h0, selValQ[2]};
      default:    rdData = '0;
    endcase
  end

  AST_CTL_MASK_APPLY: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCtl |=> ((statusQ & $past(busMask)) == ($past(busWdata[STAT_W-1:0]) & $past(busMask)))); // R2

  AST_ENG_MASK_APPLY: assert property (@(posedge clk) disable iff (!rstN)
    (engUpdEn && !strb.wrCtl) |=> ((statusQ & $past(engUpdMask)) == ($past(engUpdVal) & $past(engUpdMask)))); // R7

  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!engUpdEn && !strb.wrCtl) |=> $stable(statusQ)); // R3

  AST_SEL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == RD_SEL_INT || rdSel == RD_SEL_BR || rdSel == RD_SEL_WT)
      |-> (rdData[31:24] == 8'h0 && rdData[15:8] == 8'h0)); // R4

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPtrLo |=> (cmdPtr[REG_W-1:0] == $past(busWdata))); // R9

endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_csr_pkg::*;
#(
  parameter int NUM_CHAN  = 2,
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 32'h8000,
  parameter int CHAN_SPAN = 256
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busSel,
  input  logic                       busWrite,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [REG_W-1:0]           busWdata,
  output logic [REG_W-1:0]           busRdata,
  input  logic [NUM_CHAN-1:0]        engUpdEn,
  input  logic [NUM_CHAN*STAT_W-1:0] engUpdMask,
  input  logic [NUM_CHAN*STAT_W-1:0] engUpdVal,
  output logic [NUM_CHAN-1:0]        condIntr,
  output logic [NUM_CHAN-1:0]        condBranch,
  output logic [NUM_CHAN-1:0]        condWait,
  output logic [NUM_CHAN*2*REG_W-1:0] cmdPtr
);

  csrStrb_t [NUM_CHAN-1:0]         strb;
  rdSel_e                          rdSel;
  logic [NUM_CHAN-1:0]             rdHit;
  logic [NUM_CHAN-1:0][REG_W-1:0]  dpRd;

  dma_csr_ctrl #(
    .NUM_CHAN  (NUM_CHAN),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .CHAN_SPAN (CHAN_SPAN)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb),
    .rdSel    (rdSel),
    .rdHit    (rdHit)
  );

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_dp
    dma_csr_dp u_dp (
      .clk        (clk),
      .rstN       (rstN),
      .strb       (strb[c]),
      .busWdata   (busWdata),
      .engUpdEn   (engUpdEn[c]),
      .engUpdMask (engUpdMask[c*STAT_W +: STAT_W]),
      .engUpdVal  (engUpdVal[c*STAT_W +: STAT_W]),
      .rdSel      (rdSel),
      .rdData     (dpRd[c]),
      .condIntr   (condIntr[c]),
      .condBranch (condBranch[c]),
      .condWait   (condWait[c]),
      .cmdPtr     (cmdPtr[c*2*REG_W +: 2*REG_W])
    );
  end

  always_comb begin
    busRdata = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (rdHit[c]) busRdata = busRdata | dpRd[c];
    end
  end

endmodule

// File: tb/tb_dma_chan_csr.sv
module tb_dma_chan_csr;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  typedef struct packed {
    logic [31:0] ctl;
    logic [31:0] sel;
    logic [15:0] stat;
    logic        cond;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{32'h00FF_00A5, 32'h00F0_00A0, 16'h00A5, 1'b1},
    '{32'h000F_00FF, 32'h00FF_000F, 16'h000F, 1'b1},
    '{32'h00FF_003C, 32'h00FF_003D, 16'h003C, 1'b0},
    '{32'hFF00_AB12, 32'h0000_0000, 16'hAB00, 1'b1},
    '{32'hFFFF_1234, 32'h0003_0001, 16'h1234, 1'b0},
    '{32'hFFFF_8001, 32'h0081_0001, 16'h8001, 1'b1},
    '{32'h0F0F_FFFF, 32'h00FF_000F, 16'h0F0F, 1'b1},
    '{32'h0000_FFFF, 32'h0001_0001, 16'h0000, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NCH-1:0] engUpdEn = '0;
  logic [NCH*16-1:0] engUpdMask = '0, engUpdVal = '0;
  logic [NCH-1:0] condIntr, condBranch, condWait;
  logic [NCH*64-1:0] cmdPtr;

  int checks = 0;
  int failures = 0;
  logic [31:0] rdv;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_csr #(.NUM_CHAN(NCH)) dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .engUpdEn(engUpdEn), .engUpdMask(engUpdMask), .engUpdVal(engUpdVal),
    .condIntr(condIntr), .condBranch(condBranch), .condWait(condWait),
    .cmdPtr(cmdPtr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R6: reset state
    for (int k = 0; k < 7; k++) begin
      rd(16'h8000 + 16'(k*4), rdv);
      chk("R6 reg zero after reset", 64'(rdv), 64'h0);
    end
    chk("R6 conditions true after reset", {58'h0, condIntr, condBranch, condWait}, 64'h3F);
    chk("R6 cmdPtr zero after reset", cmdPtr[63:0], 64'h0);

    // R2/R5 table
    for (int v = 0; v < NVEC; v++) begin
      wr(16'h8000, 32'hFFFF_0000);
      wr(16'h8010, VECS[v].sel);
      wr(16'h8000, VECS[v].ctl);
      rd(16'h8004, rdv);
      chk($sformatf("R2 vector %0d status", v), 64'(rdv), 64'(VECS[v].stat));
      chk($sformatf("R5 vector %0d interrupt cond", v), 64'(condIntr[0]), 64'(VECS[v].cond));
    end

    // R2: partial writes keep unmasked bits
    wr(16'h8000, 32'h00F0_0050);
    wr(16'h8000, 32'h000F_0003);
    rd(16'h8004, rdv);
    chk("R2 unmasked bits kept", 64'(rdv), 64'h0053);

    // R3: direct status write ignored, control offset reads status
    wr(16'h8004, 32'hFFFF_FFFF);
    rd(16'h8004, rdv);
    chk("R3 status write ignored", 64'(rdv), 64'h0053);
    rd(16'h8000, rdv);
    chk("R3 control offset reads status", 64'(rdv), 64'h0053);

    // R4: reserved select bits read zero
    wr(16'h8014, 32'hAAF0_55A0);
    rd(16'h8014, rdv);
    chk("R4 select reserved zero", 64'(rdv), 64'h00F0_00A0);
    chk("R5 branch miss", 64'(condBranch[0]), 64'h0);

    // R5: branch and wait use own selects
    wr(16'h8014, 32'h00FF_0053);
    chk("R5 branch hit", 64'(condBranch[0]), 64'h1);
    wr(16'h8018, 32'h00FF_0052);
    chk("R5 wait miss", 64'(condWait[0]), 64'h0);
    chk("R5 interrupt independent", 64'(condIntr[0]), 64'h1);

    // R7: engine update alone
    @(negedge clk);
    engUpdEn = 2'b01; engUpdMask[15:0] = 16'h00FF; engUpdVal[15:0] = 16'h00AA;
    @(negedge clk);
    engUpdEn = 2'b00;
    rd(16'h8004, rdv);
    chk("R7 engine update", 64'(rdv), 64'h00AA);

    // R7: engine and bus in same cycle
    @(negedge clk);
    engUpdEn = 2'b01; engUpdMask[15:0] = 16'h00FF; engUpdVal[15:0] = 16'h0000;
    busSel = 1'b1; busWrite = 1'b1; busAddr = 16'h8000; busWdata = 32'h000F_0005;
    @(negedge clk);
    engUpdEn = 2'b00; busSel = 1'b0; busWrite = 1'b0;
    rd(16'h8004, rdv);
    chk("R7 bus wins overlap, engine keeps rest", 64'(rdv), 64'h0005);

    // R8: condition visible right after loading edge
    chk("R8 wait before", 64'(condWait[0]), 64'h0);
    wr(16'h8000, 32'h00FF_0052);
    chk("R8 wait after status edge", 64'(condWait[0]), 64'h1);

    // R9: command pointer
    wr(16'h8008, 32'hDEAD_0001);
    wr(16'h800C, 32'h1000_0040);
    rd(16'h8008, rdv);
    chk("R9 pointer high readback", 64'(rdv), 64'hDEAD_0001);
    rd(16'h800C, rdv);
    chk("R9 pointer low readback", 64'(rdv), 64'h1000_0040);
    chk("R9 cmdPtr output", cmdPtr[63:0], 64'hDEAD_0001_1000_0040);

    // R10: channel independence
    wr(16'h8100, 32'hFFFF_00FF);
    rd(16'h8104, rdv);
    chk("R10 channel 1 status", 64'(rdv), 64'h00FF);
    rd(16'h8004, rdv);
    chk("R10 channel 0 untouched", 64'(rdv), 64'h0052);
    chk("R10 channel 1 pointer untouched", cmdPtr[127:64], 64'h0);

    // R1: unused offsets and out-of-window addresses
    wr(16'h801C, 32'hFFFF_FFFF);
    rd(16'h801C, rdv);
    chk("R1 unused offset reads zero", 64'(rdv), 64'h0);
    rd(16'h8200, rdv);
    chk("R1 beyond last channel reads zero", 64'(rdv), 64'h0);
    wr(16'h8200, 32'hFFFF_0000);
    wr(16'h7F00, 32'hFFFF_0000);
    rd(16'h8004, rdv);
    chk("R1 stray writes leave channel 0", 64'(rdv), 64'h0052);
    rd(16'h8104, rdv);
    chk("R1 stray writes leave channel 1", 64'(rdv), 64'h00FF);
    rd(16'h7F04, rdv);
    chk("R1 below base reads zero", 64'(rdv), 64'h0);

    // R6: mid-run reset
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    rd(16'h8004, rdv);
    chk("R6 status cleared by reset", 64'(rdv), 64'h0);
    rd(16'h8018, rdv);
    chk("R6 select cleared by reset", 64'(rdv), 64'h0);
    chk("R6 conditions true after second reset", {58'h0, condIntr, condBranch, condWait}, 64'h3F);

    finishRun();
  end

endmodule